// File: doc/BRIEF.md
# SDRAM Bank State Command Checker

This block watches the registered command bus of an eight-bank SDRAM from the controller side and keeps its own model of every bank. Each bank runs a small state machine that moves through idle, row opening, open, reading, writing, write recovery, closing (precharge) and refreshing. The timed transitional states last for programmable cycle counts taken from configuration inputs. Every command is tested against the state of the bank or banks it targets. A command that does not fit is reported and changes nothing.

The checker is passive. It never drives the memory bus and it exerts no back-pressure, so every bus cycle is evaluated as it arrives. On each illegal command it gives a one-cycle pulse. It also captures the first offending bank and command kind into a sticky error code, which stays put until software-side logic pulses the clear input. The per-bank state vector is exported so that a scoreboard or a debug view can follow the memory.

Top module: `sdram_bank_checker`

## Requirements
- R1: A command is decoded from (cs_n, ras_n, cas_n, we_n) only when cke is high. The codes are L,H,H,H no-op; L,L,H,H activate; L,H,L,H read; L,H,L,L write; L,L,H,L precharge; L,L,L,H refresh; L,L,L,L mode set. When cs_n is high or cke is low, the cycle is a no-op and the timers keep running.
- R2: An activate to an idle bank moves that bank to opening (state code 1) for cfg_trcd cycles and then to open (2). An activate to any bank that is not idle is illegal.
- R3: A read or write to a bank that is idle, opening, closing or refreshing is illegal.
- R4: A read to an open bank moves it to reading (3) for cfg_bl cycles and then back to open. A read to a reading bank without a pending auto-close restarts the burst. A write to a reading bank is illegal.
- R5: A write to an open bank moves it to writing (4) for cfg_bl cycles, then to recovering (5) for cfg_twr cycles, then to open. While the bank is writing or recovering, a read, activate or precharge to it is illegal and a new write restarts the burst.
- R6: a10 high on a read or write requests auto-close. After the read burst, or after write recovery, the bank goes to closing (6) for cfg_trp cycles and then to idle. While an auto-close is pending, any read, write or precharge to that bank is illegal.
- R7: A precharge with a10 low targets bank ba, and with a10 high it targets all banks. It is legal for banks that are idle, open, closing, or reading without auto-close. Open and reading banks go to closing for cfg_trp cycles and then to idle. Idle and closing banks are unaffected.
- R8: A refresh or mode set is illegal unless all banks are idle. An accepted refresh puts every bank into refreshing (7) for cfg_trfc cycles, then idle. A mode set changes no state.
- R9: An illegal command changes no bank state or timer; timers still advance.
- R10: `illegal` is high in the cycle after an illegal command. err_op uses the command codes 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode set. For all-bank targets, err_bank is the lowest offending bank. The first error is held with err_valid until err_clr. If err_clr and a new illegal command arrive in the same cycle, the new error is captured.
- R11: After reset all banks read idle (0), err_valid is low and illegal is low. A timer count of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable of the memory bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | All-bank precharge / auto-close request |
| cfg_trcd | input | CNT_W | Opening duration in cycles |
| cfg_trp | input | CNT_W | Closing duration in cycles |
| cfg_trfc | input | CNT_W | Refresh duration in cycles |
| cfg_twr | input | CNT_W | Write recovery duration in cycles |
| cfg_bl | input | CNT_W | Burst duration in cycles |
| err_clr | input | 1 | Clears the held error code |
| bank_state | output | 3*NBANK | State code of each bank, bank b at bits 3b+2..3b |
| illegal | output | 1 | One-cycle pulse per illegal command |
| err_valid | output | 1 | A held error code is present |
| err_bank | output | BA_W | Bank of the held error |
| err_op | output | 3 | Command code of the held error |

## Verification
Every cycle, the embedded properties check these rules. An accepted activate always lands in opening. An idle bank can only leave to opening or refreshing. Write recovery exits only to open, closing or a new write. An accepted refresh puts every bank into refreshing. Every illegal pulse leaves a held error, and the held code is stable until cleared. The exact durations of each timed state, the auto-close path, the lowest-bank choice for all-bank commands, and the clear-versus-new-error collision are shown only by the bench scenarios. In those scenarios a behavioural model is compared with every output on every clock.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_OPENING = 3'd1,
    ST_OPEN    = 3'd2,
    ST_RD      = 3'd3,
    ST_WR      = 3'd4,
    ST_WREC    = 3'd5,
    ST_CLOSING = 3'd6,
    ST_REFR    = 3'd7
  } bank_st_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_PRE  = 3'd4,
    OP_REF  = 3'd5,
    OP_MRS  = 3'd6
  } op_e;
endpackage

// File: rtl/sbc_cmd_decode.sv
module sbc_cmd_decode
  import sbc_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output op_e  op
);
  always_comb begin
    op = OP_NONE;
    if (cke && !cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  op = OP_ACT;
        3'b101:  op = OP_RD;
        3'b100:  op = OP_WR;
        3'b010:  op = OP_PRE;
        3'b001:  op = OP_REF;
        3'b000:  op = OP_MRS;
        default: op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sbc_bank_fsm.sv
module sbc_bank_fsm
  import sbc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              op,
  input  logic             a10,
  input  logic             go,
  input  logic [CNT_W-1:0] cfg_trcd,
  input  logic [CNT_W-1:0] cfg_trp,
  input  logic [CNT_W-1:0] cfg_trfc,
  input  logic [CNT_W-1:0] cfg_twr,
  input  logic [CNT_W-1:0] cfg_bl,
  output bank_st_e         st,
  output logic             reject
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             ap_q;
  logic             starts;
  logic             timed;

  always_comb begin
    reject = 1'b0;
    unique case (op)
      OP_ACT: reject = (st != ST_IDLE);
      OP_RD:  reject = !((st == ST_OPEN) || (st == ST_RD && !ap_q));
      OP_WR:  reject = !((st == ST_OPEN) ||
                         ((st == ST_WR || st == ST_WREC) && !ap_q));
      OP_PRE: reject = !((st == ST_IDLE) || (st == ST_OPEN) ||
                         (st == ST_CLOSING) || (st == ST_RD && !ap_q));
      OP_REF, OP_MRS: reject = (st != ST_IDLE);
      default: reject = 1'b0;
    endcase
  end

  always_comb begin
    starts = 1'b0;
    if (go) begin
      unique case (op)
        OP_ACT, OP_RD, OP_WR, OP_REF: starts = 1'b1;
        OP_PRE:  starts = (st == ST_OPEN) || (st == ST_RD);
        default: starts = 1'b0;
      endcase
    end
  end

  assign timed = (st != ST_IDLE) && (st != ST_OPEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      ap_q <= 1'b0;
    end else if (starts) begin
      unique case (op)
        OP_ACT: begin st <= ST_OPENING; cnt <= cfg_trcd; end
        OP_RD:  begin st <= ST_RD; cnt <= cfg_bl; ap_q <= a10; end
        OP_WR:  begin st <= ST_WR; cnt <= cfg_bl; ap_q <= a10; end
        OP_PRE: begin st <= ST_CLOSING; cnt <= cfg_trp; ap_q <= 1'b0; end
        default: begin st <= ST_REFR; cnt <= cfg_trfc; end
      endcase
    end else if (timed) begin
      if (cnt <= ONE) begin
        unique case (st)
          ST_OPENING: st <= ST_OPEN;
          ST_RD: begin
            if (ap_q) begin st <= ST_CLOSING; cnt <= cfg_trp; ap_q <= 1'b0; end
            else st <= ST_OPEN;
          end
          ST_WR: begin st <= ST_WREC; cnt <= cfg_twr; end
          ST_WREC: begin
            if (ap_q) begin st <= ST_CLOSING; cnt <= cfg_trp; ap_q <= 1'b0; end
            else st <= ST_OPEN;
          end
          default: begin st <= ST_IDLE; ap_q <= 1'b0; end
        endcase
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

  // R2: an accepted activate always lands in the opening state
  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_ACT) |=> (st == ST_OPENING));

  // R3: an idle bank can only leave toward opening or refreshing
  p_idle_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |=> (st == ST_IDLE || st == ST_OPENING || st == ST_REFR));

  // R5: recovery ends in open, closing, or a fresh write burst
  p_wrec_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WREC) |=>
      (st == ST_WREC || st == ST_OPEN || st == ST_CLOSING || st == ST_WR));
endmodule

// File: rtl/sbc_err_log.sv
module sbc_err_log #(
  parameter int BA_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic            clr,
  input  logic [BA_W-1:0] bank_in,
  input  logic [2:0]      op_in,
  output logic            pulse,
  output logic            valid,
  output logic [BA_W-1:0] bank_q,
  output logic [2:0]      op_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse  <= 1'b0;
      valid  <= 1'b0;
      bank_q <= '0;
      op_q   <= '0;
    end else begin
      pulse <= fire;
      if (fire && (!valid || clr)) begin
        valid  <= 1'b1;
        bank_q <= bank_in;
        op_q   <= op_in;
      end else if (clr) begin
        valid  <= 1'b0;
        bank_q <= '0;
        op_q   <= '0;
      end
    end
  end

  // R10: every illegal pulse is backed by a held error code
  p_pulse_logged_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> valid);

  // R10: a held code does not change until cleared
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !clr) |=> (valid && $stable(bank_q) && $stable(op_q)));
endmodule

// File: rtl/sdram_bank_checker.sv
module sdram_bank_checker
  import sbc_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int CNT_W = 8,
  parameter int BA_W  = $clog2(NBANK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cke,
  input  logic               cs_n,
  input  logic               ras_n,
  input  logic               cas_n,
  input  logic               we_n,
  input  logic [BA_W-1:0]    ba,
  input  logic               a10,
  input  logic [CNT_W-1:0]   cfg_trcd,
  input  logic [CNT_W-1:0]   cfg_trp,
  input  logic [CNT_W-1:0]   cfg_trfc,
  input  logic [CNT_W-1:0]   cfg_twr,
  input  logic [CNT_W-1:0]   cfg_bl,
  input  logic               err_clr,
  output logic [3*NBANK-1:0] bank_state,
  output logic               illegal,
  output logic               err_valid,
  output logic [BA_W-1:0]    err_bank,
  output logic [2:0]         err_op
);
  op_e              op;
  logic [NBANK-1:0] hit;
  logic [NBANK-1:0] rej;
  logic [NBANK-1:0] bad;
  logic [NBANK-1:0] refr;
  logic             any_bad;
  logic [BA_W-1:0]  bad_bank;
  bank_st_e         st_v [NBANK];

  sbc_cmd_decode u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .op(op)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_comb begin
      unique case (op)
        OP_ACT, OP_RD, OP_WR: hit[b] = (ba == BA_W'(b));
        OP_PRE:               hit[b] = a10 || (ba == BA_W'(b));
        OP_REF, OP_MRS:       hit[b] = 1'b1;
        default:              hit[b] = 1'b0;
      endcase
    end

    sbc_bank_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .op(op), .a10(a10),
      .go(hit[b] && !any_bad),
      .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp), .cfg_trfc(cfg_trfc),
      .cfg_twr(cfg_twr), .cfg_bl(cfg_bl),
      .st(st_v[b]), .reject(rej[b])
    );

    assign bank_state[3*b +: 3] = st_v[b];
    assign refr[b] = (st_v[b] == ST_REFR);
  end

  assign bad     = hit & rej;
  assign any_bad = |bad;

  always_comb begin
    bad_bank = '0;
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (bad[b]) bad_bank = BA_W'(b);
    end
  end

  sbc_err_log #(.BA_W(BA_W)) u_err (
    .clk(clk), .rst_n(rst_n), .fire(any_bad), .clr(err_clr),
    .bank_in(bad_bank), .op_in(op),
    .pulse(illegal), .valid(err_valid), .bank_q(err_bank), .op_q(err_op)
  );

  // R8: an accepted refresh sends every bank into refreshing
  p_ref_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_REF && !any_bad) |=> (&refr));

  // R1: a deselected or clock-disabled cycle never raises the pulse
  p_nop_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !cke) |=> !illegal);
endmodule

// File: tb/sim_sdram_bank_checker.sv
`timescale 1ns/1ps
module sim_sdram_bank_checker;
  localparam int NB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [2:0] ba = '0;
  logic a10 = 1'b0;
  logic err_clr = 1'b0;
  logic [7:0] trcd = 8'd3, trp = 8'd2, trfc = 8'd5, twr = 8'd2, bl = 8'd2;
  logic [3*NB-1:0] bank_state;
  logic illegal, err_valid;
  logic [2:0] err_bank, err_op;

  always #2 clk = ~clk;

  sdram_bank_checker u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
    .cfg_trcd(trcd), .cfg_trp(trp), .cfg_trfc(trfc), .cfg_twr(twr), .cfg_bl(bl),
    .err_clr(err_clr), .bank_state(bank_state), .illegal(illegal),
    .err_valid(err_valid), .err_bank(err_bank), .err_op(err_op)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  string tag = "R11";

  // reference model (0 idle,1 opening,2 open,3 read,4 write,5 recover,6 closing,7 refresh)
  int m_st[NB], m_cnt[NB];
  bit m_ap[NB];
  bit m_ill = 0, m_ev = 0;
  int m_eb = 0, m_eo = 0;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit refuse(int st, bit ap, int op);
    case (op)
      1: return st != 0;
      2: return !(st == 2 || (st == 3 && !ap));
      3: return !(st == 2 || ((st == 4 || st == 5) && !ap));
      4: return !(st == 0 || st == 2 || st == 6 || (st == 3 && !ap));
      5, 6: return st != 0;
      default: return 0;
    endcase
  endfunction

  task automatic advance(int b);
    if (m_st[b] == 0 || m_st[b] == 2) return;
    if (m_cnt[b] > 1) begin m_cnt[b]--; return; end
    case (m_st[b])
      1: m_st[b] = 2;
      3, 5: if (m_ap[b]) begin m_st[b] = 6; m_cnt[b] = trp; m_ap[b] = 0; end
            else m_st[b] = 2;
      4: begin m_st[b] = 5; m_cnt[b] = twr; end
      default: begin m_st[b] = 0; m_ap[b] = 0; end
    endcase
  endtask

  task automatic model_step(int op, int bk, bit hi, bit clr);
    bit tgt[NB];
    bit bad = 0;
    int bb = 0;
    for (int b = 0; b < NB; b++)
      tgt[b] = (op >= 1 && op <= 3) ? (bk == b) : (op == 4) ? (hi || bk == b) : (op >= 5);
    for (int b = NB - 1; b >= 0; b--)
      if (tgt[b] && refuse(m_st[b], m_ap[b], op)) begin bad = 1; bb = b; end
    m_ill = bad;
    if (bad && (!m_ev || clr)) begin m_ev = 1; m_eb = bb; m_eo = op; end
    else if (clr) begin m_ev = 0; m_eb = 0; m_eo = 0; end
    for (int b = 0; b < NB; b++) begin
      if (tgt[b] && !bad && op != 6 && !(op == 4 && m_st[b] != 2 && m_st[b] != 3)) begin
        case (op)
          1: begin m_st[b] = 1; m_cnt[b] = trcd; end
          2: begin m_st[b] = 3; m_cnt[b] = bl; m_ap[b] = hi; end
          3: begin m_st[b] = 4; m_cnt[b] = bl; m_ap[b] = hi; end
          4: begin m_st[b] = 6; m_cnt[b] = trp; m_ap[b] = 0; end
          default: begin m_st[b] = 7; m_cnt[b] = trfc; end
        endcase
      end else advance(b);
    end
  endtask

  task automatic compare_all();
    for (int b = 0; b < NB; b++) chk($sformatf("bank%0d state", b), bank_state[3*b +: 3], m_st[b]);
    chk("illegal", illegal, m_ill);
    chk("err_valid", err_valid, m_ev);
    chk("err_bank", err_bank, m_eb);
    chk("err_op", err_op, m_eo);
  endtask

  // one bus cycle; called at a falling edge, compares at the next one
  task automatic cyc(int op, int bk = 0, bit hi = 0, bit clr = 0, bit en = 1, bit sel = 1);
    int eff;
    cke = en; ba = 3'(bk); a10 = hi; err_clr = clr;
    cs_n = !sel;
    case (op)
      1: {ras_n, cas_n, we_n} = 3'b011;
      2: {ras_n, cas_n, we_n} = 3'b101;
      3: {ras_n, cas_n, we_n} = 3'b100;
      4: {ras_n, cas_n, we_n} = 3'b010;
      5: {ras_n, cas_n, we_n} = 3'b001;
      6: {ras_n, cas_n, we_n} = 3'b000;
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
    eff = (en && sel) ? op : 0;
    model_step(eff, bk, hi, clr);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin m_st[b] = 0; m_cnt[b] = 0; m_ap[b] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tag = "R11"; compare_all();
    idle(1);

    tag = "R8";  cyc(5); idle(6); cyc(6); idle(1);
    tag = "R2";  cyc(1, 0); cyc(1, 0); idle(1);
    tag = "R3";  cyc(2, 1); cyc(3, 5); idle(1);
    tag = "R10"; cyc(0, 0, 0, 1); idle(1);
    tag = "R4";  cyc(2, 0); cyc(2, 0); cyc(3, 0); idle(3);
    tag = "R10"; cyc(0, 0, 0, 1);
    tag = "R5";  cyc(3, 0); idle(2); cyc(2, 0); cyc(1, 0); cyc(4, 0); cyc(3, 0); idle(5);
    tag = "R10"; cyc(0, 0, 0, 1);
    tag = "R6";  cyc(1, 2); idle(3); cyc(2, 2, 1); cyc(2, 2); cyc(4, 2); idle(5);
                 cyc(1, 3); idle(3); cyc(3, 3, 1); cyc(3, 3); idle(7);
    tag = "R10"; cyc(0, 0, 0, 1);
    tag = "R7";  cyc(1, 4); idle(3); cyc(4, 4); cyc(4, 4); idle(3);
                 cyc(1, 5); cyc(4, 0, 1); idle(3); cyc(4, 0, 1); idle(3);
    tag = "R8";  cyc(1, 6); cyc(5); cyc(6, 0, 0, 1); idle(3); cyc(4, 0, 1); idle(3);
    tag = "R1";  cyc(1, 7, 0, 1, 0); cyc(2, 7, 0, 0, 1, 0); idle(1); cyc(1, 7); idle(4);
    tag = "R9";  cyc(1, 7); cyc(5); idle(2);
    tag = "R10"; cyc(2, 1); cyc(3, 1); cyc(4, 7, 0, 1); cyc(0, 0, 0, 1); idle(1);
    tag = "R11"; trcd = 8'd0; cyc(1, 1); idle(2); trcd = 8'd3; cyc(4, 0, 1); idle(4);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule